// File: doc/BRIEF.md
# Multi-source reset combiner with power-up hold

This block turns several independent, asynchronous, active-low reset requests into a single active-low reset that is synchronous to one clock. Every request line is retimed through its own three-flop synchronizer, so a change on any line reaches the merge logic a fixed number of cycles after it is first sampled. The merged release condition is true only when all retimed lines are high and a built-in power-up timer has expired. The result then passes through a shift chain of configurable depth before it leaves the block.

The power-up timer is an 8-bit counter that starts at zero when the device is configured. It counts one step per clock, stops at its all-ones value and then raises a registered done flag that never drops again. Until that flag is up, the output stays asserted whatever the request lines do. After that, the output follows the AND of the request lines with a fixed latency. A parameter set with zero request lines or zero output stages is rejected at elaboration.

Top module: `rst_merge_gen`

## Requirements
- R1: From configuration, rst_out_n is 0, and it stays 0 on every clock edge before edge 256+OUT_REG_DEPTH (edges counted from 1), whatever rst_src_n does.
- R2: With every rst_src_n bit held at 1 from the start, rst_out_n is still 0 after edge 255+OUT_REG_DEPTH and becomes 1 after edge 256+OUT_REG_DEPTH.
- R3: Once power-up is done, if any single bit of the rst_src_n value sampled at edge j is 0, rst_out_n is 0 after edge j+OUT_REG_DEPTH+2.
- R4: Once power-up is done, if all bits of the rst_src_n value sampled at edge j are 1, rst_out_n is 1 after edge j+OUT_REG_DEPTH+2. The power-up hold is one-time and does not return.
- R5: A low pulse lasting one clock on any one input, surrounded by all-high samples, gives exactly one cycle of low output OUT_REG_DEPTH+2 edges later. The path neither stretches nor filters the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the output reset is synchronous to |
| rst_src_n | input | N_SRC | Asynchronous active-low reset requests, one bit per source |
| rst_out_n | output | 1 | Combined active-low reset, synchronous to clk |

## Verification
While the timer runs, the inputs step through a counting pattern. This shows that no input pattern can release reset early, and it pins the exact release edge against an off-by-one in the counter or the done flag. After release, every value of the input vector is held for several cycles. This tells an AND merge apart from an OR merge or a dropped bit, and it measures the latency from input to output. Single-cycle low pulses on each bit separate a plain retiming path from one that filters or stretches pulses. A long pseudo-random stretch catches any history-dependent error.

// File: rtl/rmg_pkg.sv
package rmg_pkg;
  // number of retiming flops on each reset request line
  localparam int unsigned SYNC_DEPTH = 3;
  // width of the power-up hold counter
  localparam int unsigned HOLD_W = 8;
endpackage

// File: rtl/rmg_sync_bank.sv
module rmg_sync_bank #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk,
  input  logic [N_SRC-1:0] src_n,
  output logic [N_SRC-1:0] sync_n
);
  import rmg_pkg::*;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    logic [SYNC_DEPTH-1:0] pipe = '0;
    logic [SYNC_DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe[SYNC_DEPTH-2:0], src_n[i]};
    end

    always_ff @(posedge clk) begin
      pipe <= pipe_d;
    end

    assign sync_n[i] = pipe[SYNC_DEPTH-1];
  end
endmodule

// File: rtl/rmg_pwrup.sv
module rmg_pwrup #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt = '0;
  logic             done_q = 1'b0;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_max;

  always_comb begin
    at_max = &cnt;
    cnt_en = !at_max;
    cnt_d  = cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (cnt_en) begin
      cnt <= cnt_d;
    end
    done_q <= at_max;
  end

  assign cnt_o  = cnt;
  assign done_o = done_q;
endmodule

// File: rtl/rmg_out_chain.sv
module rmg_out_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic d_in,
  output logic q_out
);
  logic [DEPTH-1:0] stg = '0;
  logic [DEPTH-1:0] stg_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == DEPTH - 1) begin : g_head
      assign stg_d[i] = d_in;
    end else begin : g_body
      assign stg_d[i] = stg[i+1];
    end
  end

  always_ff @(posedge clk) begin
    stg <= stg_d;
  end

  assign q_out = stg[0];
endmodule

// File: rtl/rst_merge_gen.sv
module rst_merge_gen #(
  parameter int unsigned N_SRC         = 3,
  parameter int unsigned OUT_REG_DEPTH = 2
) (
  input  logic             clk,
  input  logic [N_SRC-1:0] rst_src_n,
  output logic             rst_out_n
);
  import rmg_pkg::*;

  if (N_SRC < 1) begin : g_bad_src
    $error("rst_merge_gen: N_SRC must be at least 1");
  end
  if (OUT_REG_DEPTH < 1) begin : g_bad_depth
    $error("rst_merge_gen: OUT_REG_DEPTH must be at least 1");
  end

  logic [N_SRC-1:0]  sync_n;
  logic [HOLD_W-1:0] pwr_cnt;
  logic              pwr_done;
  logic              release_c;

  rmg_sync_bank #(.N_SRC(N_SRC)) sync_i (
    .clk    (clk),
    .src_n  (rst_src_n),
    .sync_n (sync_n)
  );

  rmg_pwrup #(.CNT_W(HOLD_W)) pwrup_i (
    .clk    (clk),
    .cnt_o  (pwr_cnt),
    .done_o (pwr_done)
  );

  always_comb begin
    release_c = pwr_done && (&sync_n);
  end

  rmg_out_chain #(.DEPTH(OUT_REG_DEPTH)) chain_i (
    .clk   (clk),
    .d_in  (release_c),
    .q_out (rst_out_n)
  );
endmodule

// File: rtl/rst_merge_gen_chk.sv
module rst_merge_gen_chk #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic [N_SRC-1:0] rst_src_n,
  input logic             rst_out_n,
  input logic             pwr_done,
  input logic [CNT_W-1:0] pwr_cnt,
  input logic             release_c
);
  logic [2:0] age = '0;
  logic       live;
  logic       hist_ok;

  always_ff @(posedge clk) begin
    if (age != 3'd4) begin
      age <= age + 3'd1;
    end
  end

  assign live    = (age != 3'd0);
  assign hist_ok = (age == 3'd4);

  // R1
  out_before_pwrup_chk: assert property (@(posedge clk) disable iff (!live)
    rst_out_n |-> pwr_done);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!live)
    pwr_done |=> pwr_done);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!live)
    !(&pwr_cnt) |=> (pwr_cnt == $past(pwr_cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R2
  cnt_full_done_chk: assert property (@(posedge clk) disable iff (!live)
    (&pwr_cnt) |=> pwr_done);

  // R2
  done_implies_full_chk: assert property (@(posedge clk) disable iff (!live)
    pwr_done |-> (&pwr_cnt));

  // R3
  low_src_holds_chk: assert property (@(posedge clk) disable iff (!hist_ok)
    !(&$past(rst_src_n, 3)) |-> !release_c);

  // R4
  all_high_release_chk: assert property (@(posedge clk) disable iff (!hist_ok)
    (pwr_done && (&$past(rst_src_n, 3))) |-> release_c);
endmodule

bind rst_merge_gen rst_merge_gen_chk #(
  .N_SRC (N_SRC),
  .CNT_W (rmg_pkg::HOLD_W)
) chk_i (
  .clk       (clk),
  .rst_src_n (rst_src_n),
  .rst_out_n (rst_out_n),
  .pwr_done  (pwr_done),
  .pwr_cnt   (pwr_cnt),
  .release_c (release_c)
);

// File: tb/rst_merge_gen_tb_top.sv
module rst_merge_gen_tb_top;
  localparam int N    = 3;
  localparam int D    = 2;
  localparam int REL  = 256 + D;
  localparam int HMAX = 2048;

  logic         clk = 1'b0;
  logic [N-1:0] src_n = '1;
  logic         out_n;

  int n_chk  = 0;
  int n_fail = 0;
  int k      = 0;
  bit fin    = 1'b0;
  logic [N-1:0] hist [0:HMAX-1];

  always #10 clk = ~clk;

  rst_merge_gen #(.N_SRC(N), .OUT_REG_DEPTH(D)) dut_i (
    .clk       (clk),
    .rst_src_n (src_n),
    .rst_out_n (out_n)
  );

  function automatic logic exp_at(int e);
    if (e < REL) return 1'b0;
    if (e - D - 2 < 1) return 1'b0;
    return &hist[e-D-2];
  endfunction

  task automatic check(string tag, logic exp);
    n_chk++;
    if (out_n !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: rst_out_n=%b expected %b", tag, k, out_n, exp);
    end
  endtask

  task automatic tick(logic [N-1:0] v, string tag);
    string t;
    src_n = v;
    @(posedge clk);
    k++;
    hist[k] = v;
    @(negedge clk);
    if (k == REL || k == REL - 1) t = "R2";
    else if (k < REL)             t = "R1";
    else                          t = tag;
    check(t, exp_at(k));
  endtask

  initial begin
    logic [15:0] lfsr;
    #5;
    // R1: asserted from configuration, before any edge
    check("R1", 1'b0);
    // R1: inputs toggle while the hold timer runs
    for (int i = 0; i < 240; i++) tick(N'(i), "R1");
    // R2: all high up to and past release
    while (k < REL + 10) tick('1, "R2");
    // R3 / R4: every input value held, then all high
    for (int p = 0; p < (1 << N); p++) begin
      repeat (6) tick(N'(p), (p == (1 << N) - 1) ? "R4" : "R3");
      repeat (6) tick('1, "R4");
    end
    // R5: one-cycle low pulse on each bit
    for (int b = 0; b < N; b++) begin
      tick(~(N'(1) << b), "R5");
      repeat (6) tick('1, "R5");
    end
    // R3: pseudo-random stretch
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick((lfsr[3:0] == 4'h0) ? N'(lfsr[6:4]) : '1, "R3");
    end
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, edge %0d expected end", k);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule